// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block is a first-in first-out buffer of 9-bit words whose write side and read side run on independent clocks and share one asynchronous active-low reset. The writer presents a word with `wr_en` on a rising `wr_clk` edge; the reader asserts `rd_en` on a rising `rd_clk` edge and finds the word on `rd_data` after that edge. The storage depth is a power-of-two parameter (64 up to 8192 words).

Four active-low status flags report the fill level. Full and almost-full belong to the write clock; empty and almost-empty belong to the read clock. Each side sees the other side's pointer through Gray-coded pointers and a two-stage synchroniser, so a flag may be released a few cycles late but is never raised late. Two threshold registers, an almost-full margin `m` and an almost-empty margin `n`, are loaded from the write side and both return to 7 on reset.

Top module: `afifo_pflag`

## Requirements
- R1: Words leave in the order they were accepted. `rd_data` is registered and shows the word read on the read-clock edge at which `rd_en` was sampled high with `empty_n` high. At other times it keeps its value. It is 0 after reset.
- R2: With no reads since reset, `full_n` falls at the write-clock edge that stores word number DEPTH. It is high after every earlier write.
- R3: A write presented while `full_n` is low stores nothing and leaves the write pointer unchanged.
- R4: `empty_n` falls at the read-clock edge that removes the last stored word. A read presented while `empty_n` is low leaves the read pointer and `rd_data` unchanged.
- R5: `afull_n` is low when the fill level is at least DEPTH−m. With no reads since reset, it falls at the write-clock edge that stores word number DEPTH−m.
- R6: `aempty_n` is low when the fill level is n or less. It is high once n+1 words are stored and the write pointer has crossed into the read domain.
- R7: Once both pointers have crossed, the flags `{full_n, afull_n, aempty_n, empty_n}` follow the fill level as below. At 0 words they read 1100. From 1 to n words they read 1101. From n+1 to DEPTH−m−1 words they read 1111. From DEPTH−m to DEPTH−1 words they read 1011. At DEPTH words they read 0011.
- R8: While `rst_n` is low, both pointers and both synchroniser chains are cleared. During reset `empty_n` and `aempty_n` are low and `full_n` and `afull_n` are high. Both margins return to 7.
- R9: At a write-clock edge with `ofs_load` high, `ofs_value` is loaded into a margin register. `ofs_sel`=1 selects `m` and `ofs_sel`=0 selects `n`. The flags use the new value from then on. Margins are changed only while the FIFO is idle, and they must be less than DEPTH.
- R10: Full and almost-full change only on `wr_clk` edges, and empty and almost-empty only on `rd_clk` edges. Each flag is computed from a synchronised copy of the other side's pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low, common to both sides |
| wr_en | input | 1 | Write request, sampled on rising `wr_clk` |
| wr_data | input | DATA_W | Word to store |
| full_n | output | 1 | Low when DEPTH words are stored |
| afull_n | output | 1 | Low when at least DEPTH−m words are stored |
| rd_en | input | 1 | Read request, sampled on rising `rd_clk` |
| rd_data | output | DATA_W | Last word read (registered) |
| empty_n | output | 1 | Low when no word is stored |
| aempty_n | output | 1 | Low when n or fewer words are stored |
| ofs_load | input | 1 | Load strobe for a margin register (write clock) |
| ofs_sel | input | 1 | 1 selects margin m (almost-full), 0 selects margin n (almost-empty) |
| ofs_value | input | OFS_W | Margin value to load |

## Verification
The bound checker watches, on every edge of the owning clock, the following properties: a blocked write or read never moves a pointer; a full FIFO is always almost-full and an empty one always almost-empty; the last-slot write and the last-word read raise the full and empty flags on the very next edge; and the reset values of the flags. Only the bench's scenarios show the data order across a burst, the whole status table band by band after the pointers have crossed, the exact write numbers at which full and almost-full fall, the effect of loaded margins, and the return of both margins to 7 after reset.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

  // Widest pointer handled by the helper functions (8192 words + wrap bit).
  localparam int G_W = 16;

  function automatic logic [G_W-1:0] bin2gray(input logic [G_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [G_W-1:0] gray2bin(input logic [G_W-1:0] g);
    logic [G_W-1:0] b;
    b[G_W-1] = g[G_W-1];
    for (int i = G_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  // Level has reached the almost-full band: level >= depth - margin.
  function automatic logic near_top(input logic [31:0] level,
                                    input logic [31:0] margin,
                                    input logic [31:0] depth);
    return (level + margin) >= depth;
  endfunction

  // Level is inside the almost-empty band: level <= margin.
  function automatic logic near_bottom(input logic [31:0] level,
                                       input logic [31:0] margin);
    return level <= margin;
  endfunction

endpackage

// File: rtl/afifo_sync.sv
module afifo_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/afifo_mem.sv
module afifo_mem #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 6
) (
  input  logic              wr_clk,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] store [WORDS];

  always_ff @(posedge wr_clk) begin
    if (wr_fire) store[wr_addr] <= wr_data;
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n)       rd_data <= '0;
    else if (rd_fire) rd_data <= store[rd_addr];
  end
endmodule

// File: rtl/afifo_wr_ctl.sv
module afifo_wr_ctl
  import afifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int OFS_W = 13,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PW     = ADDR_W + 1
) (
  input  logic             wr_clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PW-1:0]    rsync_gray,
  input  logic [OFS_W-1:0] top_margin,
  output logic             wr_fire,
  output logic [PW-1:0]    wptr_bin,
  output logic [PW-1:0]    wptr_gray,
  output logic [PW-1:0]    wr_level,
  output logic             full_n,
  output logic             afull_n
);
  logic [PW-1:0] rsync_bin;
  logic [PW-1:0] wptr_next;
  logic [PW-1:0] level_next;

  assign rsync_bin  = PW'(gray2bin(G_W'(rsync_gray)));
  assign wr_fire    = wr_en & full_n;
  assign wptr_next  = wptr_bin + PW'(wr_fire);
  assign wr_level   = wptr_bin - rsync_bin;
  assign level_next = wptr_next - rsync_bin;

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_bin  <= '0;
      wptr_gray <= '0;
      full_n    <= 1'b1;
      afull_n   <= 1'b1;
    end else begin
      wptr_bin  <= wptr_next;
      wptr_gray <= PW'(bin2gray(G_W'(wptr_next)));
      full_n    <= (level_next != PW'(DEPTH));
      afull_n   <= !near_top(32'(level_next), 32'(top_margin), 32'(DEPTH));
    end
  end
endmodule

// File: rtl/afifo_rd_ctl.sv
module afifo_rd_ctl
  import afifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int OFS_W = 13,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PW     = ADDR_W + 1
) (
  input  logic             rd_clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [PW-1:0]    wsync_gray,
  input  logic [OFS_W-1:0] bottom_margin,
  output logic             rd_fire,
  output logic [PW-1:0]    rptr_bin,
  output logic [PW-1:0]    rptr_gray,
  output logic [PW-1:0]    rd_level,
  output logic             empty_n,
  output logic             aempty_n
);
  logic [PW-1:0] wsync_bin;
  logic [PW-1:0] rptr_next;
  logic [PW-1:0] level_next;

  assign wsync_bin  = PW'(gray2bin(G_W'(wsync_gray)));
  assign rd_fire    = rd_en & empty_n;
  assign rptr_next  = rptr_bin + PW'(rd_fire);
  assign rd_level   = wsync_bin - rptr_bin;
  assign level_next = wsync_bin - rptr_next;

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_bin  <= '0;
      rptr_gray <= '0;
      empty_n   <= 1'b0;
      aempty_n  <= 1'b0;
    end else begin
      rptr_bin  <= rptr_next;
      rptr_gray <= PW'(bin2gray(G_W'(rptr_next)));
      empty_n   <= (level_next != '0);
      aempty_n  <= !near_bottom(32'(level_next), 32'(bottom_margin));
    end
  end
endmodule

// File: rtl/afifo_pflag.sv
module afifo_pflag #(
  parameter int DATA_W      = 9,
  parameter int DEPTH       = 64,
  parameter int OFS_W       = 13,
  parameter int OFS_DEFAULT = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full_n,
  output logic              afull_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty_n,
  output logic              aempty_n,
  input  logic              ofs_load,
  input  logic              ofs_sel,
  input  logic [OFS_W-1:0]  ofs_value
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PW     = ADDR_W + 1;

  // Named internal events, also used by the bound checker.
  logic          wr_fire, rd_fire;
  logic [PW-1:0] wptr_bin, wptr_gray, rptr_bin, rptr_gray;
  logic [PW-1:0] wsync_gray, rsync_gray;
  logic [PW-1:0] wr_level, rd_level;

  // Margin registers, write domain. The bottom margin is read by the
  // read side as a quasi-static value: it changes only while idle.
  logic [OFS_W-1:0] top_margin, bottom_margin;

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      top_margin    <= OFS_W'(OFS_DEFAULT);
      bottom_margin <= OFS_W'(OFS_DEFAULT);
    end else if (ofs_load) begin
      if (ofs_sel) top_margin    <= ofs_value;
      else         bottom_margin <= ofs_value;
    end
  end

  afifo_wr_ctl #(.DEPTH(DEPTH), .OFS_W(OFS_W)) u_wr (
    .wr_clk    (wr_clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rsync_gray(rsync_gray),
    .top_margin(top_margin),
    .wr_fire   (wr_fire),
    .wptr_bin  (wptr_bin),
    .wptr_gray (wptr_gray),
    .wr_level  (wr_level),
    .full_n    (full_n),
    .afull_n   (afull_n)
  );

  afifo_rd_ctl #(.DEPTH(DEPTH), .OFS_W(OFS_W)) u_rd (
    .rd_clk       (rd_clk),
    .rst_n        (rst_n),
    .rd_en        (rd_en),
    .wsync_gray   (wsync_gray),
    .bottom_margin(bottom_margin),
    .rd_fire      (rd_fire),
    .rptr_bin     (rptr_bin),
    .rptr_gray    (rptr_gray),
    .rd_level     (rd_level),
    .empty_n      (empty_n),
    .aempty_n     (aempty_n)
  );

  afifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk  (rd_clk),
    .rst_n(rst_n),
    .d    (wptr_gray),
    .q    (wsync_gray)
  );

  afifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk  (wr_clk),
    .rst_n(rst_n),
    .d    (rptr_gray),
    .q    (rsync_gray)
  );

  afifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wr_clk (wr_clk),
    .wr_fire(wr_fire),
    .wr_addr(wptr_bin[ADDR_W-1:0]),
    .wr_data(wr_data),
    .rd_clk (rd_clk),
    .rst_n  (rst_n),
    .rd_fire(rd_fire),
    .rd_addr(rptr_bin[ADDR_W-1:0]),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/afifo_pflag_chk.sv
module afifo_pflag_chk #(
  parameter int DEPTH = 64,
  parameter int PW    = 7
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_n,
  input logic          wr_fire,
  input logic          rd_fire,
  input logic [PW-1:0] wptr_bin,
  input logic [PW-1:0] rptr_bin,
  input logic [PW-1:0] wr_level,
  input logic [PW-1:0] rd_level,
  input logic          full_n,
  input logic          afull_n,
  input logic          empty_n,
  input logic          aempty_n
);
  // R3: a write against a full FIFO does not move the write pointer
  p_no_overflow_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |=> $stable(wptr_bin));

  // R4: a read against an empty FIFO does not move the read pointer
  p_no_underflow_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |=> $stable(rptr_bin));

  // R2: storing into the last free slot raises full on the next edge
  p_full_on_last_slot_r2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_fire && wr_level == PW'(DEPTH - 1)) |=> !full_n);

  // R4: taking the last word raises empty on the next edge
  p_empty_on_last_word_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_fire && rd_level == PW'(1)) |=> !empty_n);

  // R7: full implies almost-full
  p_full_in_top_band_r7: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |-> !afull_n);

  // R7: empty implies almost-empty
  p_empty_in_bottom_band_r7: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);

  // R8: flag values held during reset, per domain
  p_reset_wr_flags_r8: assert property (@(posedge wr_clk)
    !rst_n |-> (full_n && afull_n));

  p_reset_rd_flags_r8: assert property (@(posedge rd_clk)
    !rst_n |-> (!empty_n && !aempty_n));
endmodule

bind afifo_pflag afifo_pflag_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .wr_clk  (wr_clk),
  .rd_clk  (rd_clk),
  .rst_n   (rst_n),
  .wr_fire (wr_fire),
  .rd_fire (rd_fire),
  .wptr_bin(wptr_bin),
  .rptr_bin(rptr_bin),
  .wr_level(wr_level),
  .rd_level(rd_level),
  .full_n  (full_n),
  .afull_n (afull_n),
  .empty_n (empty_n),
  .aempty_n(aempty_n)
);

// File: tb/afifo_pflag_tb.sv
module afifo_pflag_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = CLK_PERIOD + 4;
  localparam int DW    = 9;
  localparam int DEPTH = 64;
  localparam int OW    = 13;

  logic          wr_clk = 1'b0, rd_clk = 1'b0, rst_n;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          full_n, afull_n, empty_n, aempty_n;
  logic          ofs_load = 1'b0, ofs_sel = 1'b0;
  logic [OW-1:0] ofs_value = '0;

  always #(CLK_PERIOD / 2) wr_clk = ~wr_clk;
  always #(RD_PERIOD / 2)  rd_clk = ~rd_clk;

  afifo_pflag #(.DATA_W(DW), .DEPTH(DEPTH), .OFS_W(OW)) u_dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_data(wr_data), .full_n(full_n), .afull_n(afull_n),
    .rd_en(rd_en), .rd_data(rd_data), .empty_n(empty_n), .aempty_n(aempty_n),
    .ofs_load(ofs_load), .ofs_sel(ofs_sel), .ofs_value(ofs_value)
  );

  int n_chk  = 0;
  int n_fail = 0;

  // Reference queue
  logic [DW-1:0] mq [DEPTH];
  int head = 0, tail = 0, cnt = 0;
  logic [DW-1:0] last_rd = '0;
  logic [DW-1:0] next_val = 9'h001;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Flag vector order {full_n, afull_n, aempty_n, empty_n}
  function automatic logic [3:0] flags();
    return {full_n, afull_n, aempty_n, empty_n};
  endfunction

  task automatic settle();
    repeat (5) @(negedge rd_clk);
    repeat (5) @(negedge wr_clk);
  endtask

  task automatic model_reset();
    head = 0; tail = 0; cnt = 0; last_rd = '0;
  endtask

  // Burst of writes on consecutive write clocks
  task automatic wr_burst(input int n);
    @(negedge wr_clk);
    wr_en = 1'b1;
    for (int k = 0; k < n; k++) begin
      wr_data = next_val;
      if (cnt < DEPTH) begin
        mq[tail] = next_val; tail = (tail + 1) % DEPTH; cnt++;
      end
      next_val = next_val + 9'd3;
      @(negedge wr_clk);
    end
    wr_en = 1'b0;
  endtask

  // Burst of reads, each returned word compared (R1, R4)
  task automatic rd_burst(input int n);
    @(negedge rd_clk);
    rd_en = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(negedge rd_clk);
      if (cnt > 0) begin
        last_rd = mq[head]; head = (head + 1) % DEPTH; cnt--;
        check("R1", "read data order", 32'(rd_data), 32'(last_rd));
      end else begin
        check("R4", "data held on empty read", 32'(rd_data), 32'(last_rd));
      end
    end
    rd_en = 1'b0;
  endtask

  task automatic load_margin(input logic sel, input int val);
    @(negedge wr_clk);
    ofs_load = 1'b1; ofs_sel = sel; ofs_value = OW'(val);
    @(negedge wr_clk);
    ofs_load = 1'b0;
  endtask

  typedef struct packed {
    logic       is_read;
    logic [7:0] amount;
    logic [3:0] exp_flags;
  } vec_t;

  // Walk of the status table with default margins m = n = 7 (R7)
  localparam vec_t VECS [15] = '{
    '{1'b0, 8'd1,  4'b1101},  // 1 word
    '{1'b0, 8'd6,  4'b1101},  // 7 = n
    '{1'b0, 8'd1,  4'b1111},  // 8 = n+1
    '{1'b0, 8'd48, 4'b1111},  // 56 = DEPTH-m-1
    '{1'b0, 8'd1,  4'b1011},  // 57 = DEPTH-m
    '{1'b0, 8'd6,  4'b1011},  // 63
    '{1'b0, 8'd1,  4'b0011},  // 64 full
    '{1'b0, 8'd3,  4'b0011},  // writes while full, ignored (R3)
    '{1'b1, 8'd1,  4'b1011},  // 63
    '{1'b1, 8'd6,  4'b1011},  // 57
    '{1'b1, 8'd1,  4'b1111},  // 56
    '{1'b1, 8'd48, 4'b1111},  // 8
    '{1'b1, 8'd1,  4'b1101},  // 7
    '{1'b1, 8'd7,  4'b1100},  // 0
    '{1'b1, 8'd2,  4'b1100}   // reads while empty, ignored (R4)
  };

  bit done = 1'b0;

  initial begin
    repeat (150000) @(posedge wr_clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge wr_clk);
    check("R8", "flags in reset", 32'(flags()), 32'(4'b1100));
    check("R1", "rd_data in reset", 32'(rd_data), 32'd0);
    rst_n = 1'b1;
    settle();
    check("R8", "flags after reset", 32'(flags()), 32'(4'b1100));

    for (int v = 0; v < 15; v++) begin
      if (VECS[v].is_read) rd_burst(int'(VECS[v].amount));
      else                 wr_burst(int'(VECS[v].amount));
      settle();
      check("R7", $sformatf("status vector %0d", v),
            32'(flags()), 32'(VECS[v].exp_flags));
    end

    // Exact write numbers at which almost-full and full fall (R2, R5)
    for (int i = 1; i <= DEPTH; i++) begin
      wr_burst(1);
      check("R5", $sformatf("afull_n after write %0d", i),
            32'(afull_n), 32'(i < DEPTH - 7));
      check("R2", $sformatf("full_n after write %0d", i),
            32'(full_n), 32'(i < DEPTH));
    end
    settle();
    // Exact read edge at which empty falls (R4)
    for (int j = 1; j <= DEPTH; j++) begin
      rd_burst(1);
      check("R4", $sformatf("empty_n after read %0d", j),
            32'(empty_n), 32'(j < DEPTH));
    end
    settle();

    // Loaded margins: m = 2, n = 3 (R9)
    load_margin(1'b1, 2);
    load_margin(1'b0, 3);
    wr_burst(3); settle();
    check("R9", "aempty_n at 3 words, n=3", 32'(aempty_n), 32'd0);
    wr_burst(1); settle();
    check("R6", "aempty_n at 4 words, n=3", 32'(aempty_n), 32'd1);
    wr_burst(57); settle();
    check("R9", "afull_n at 61 words, m=2", 32'(afull_n), 32'd1);
    wr_burst(1); settle();
    check("R9", "afull_n at 62 words, m=2", 32'(afull_n), 32'd0);

    // Reset while holding data restores flags and margins (R8)
    @(negedge wr_clk);
    rst_n = 1'b0;
    repeat (3) @(negedge wr_clk);
    check("R8", "flags in reset with data", 32'(flags()), 32'(4'b1100));
    rst_n = 1'b1;
    model_reset();
    settle();
    check("R8", "flags after second reset", 32'(flags()), 32'(4'b1100));
    wr_burst(7); settle();
    check("R8", "aempty_n at 7 words, n back to 7", 32'(aempty_n), 32'd0);
    wr_burst(1); settle();
    check("R6", "aempty_n at 8 words", 32'(aempty_n), 32'd1);
    wr_burst(49); settle();
    check("R8", "afull_n at 57 words, m back to 7", 32'(afull_n), 32'd0);
    rd_burst(57); settle();
    check("R10", "flags after full drain", 32'(flags()), 32'(4'b1100));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule